// File: doc/BRIEF.md
# Window Watchdog Timer

A memory-mapped watchdog that splits every timeout period into two back-to-back phases. The first phase is a closed window, in which a restart is forbidden. The second is an open window, in which a restart is expected. Each phase length is a count of clock cycles that software programs. A restart issued while the open window runs reloads the whole sequence and starts again from the closed window. A restart issued during the closed window is a fault, and so is a period that passes with no restart. Either fault raises a reset output, which stays high until the system reset input clears it.

Software talks to the block through 32-bit words with single-cycle read and write strobes. A write to the control/status word needs protection. Software must first set the unlock flag, and that flag is consumed by the next control/status write. The window-length words may be written at any time. A new length takes effect only when the watchdog is next enabled or restarted. A sticky status flag records that a fault occurred, and a second bit records which kind of fault it was.

Top module: `win_watchdog`

## Requirements
- R1: After the asynchronous active-low reset, every register reads 0 and `wdg_rst` is low.
- R2: A write to the control word (byte offset 0x04) takes effect only if bit 0 of the unlock word (offset 0x00) is set. Any control-word write clears the unlock flag, whether it was honoured or not, and the cleared flag reads back as 0.
- R3: An honoured control-word write with bit 0 = 1 starts the watchdog from idle. With closed length C (offset 0x0C) and open length O (offset 0x10), both at least 1, and no restart, `wdg_rst` is still low C+O-1 cycles after the enabling edge and high C+O cycles after it.
- R4: A restart (control-word write with bits 0 and 8 set) that is sampled in any of the C cycles after the closed window begins raises `wdg_rst` in the next cycle. This includes the last closed cycle. The fault is recorded as early: bit 17 = 1 and bit 16 = 1.
- R5: A restart sampled in any of the O open-window cycles, first and last included, starts a new closed window. The next expiry then falls C+O cycles after that restart.
- R6: Once `wdg_rst` is high, it stays high until `rst_n` is asserted. Control-word writes do not lower it.
- R7: A fault sets bit 16. A timeout fault leaves bit 17 at 0. An honoured control write with bit 16 = 1 clears bits 16 and 17.
- R8: The restart bit (bit 8) always reads back as 0.
- R9: An honoured control write with bit 0 = 0 stops the watchdog, and no reset follows. A restart while the watchdog is disabled is ignored.
- R10: Window-length writes made while the watchdog runs do not alter the current period.
- R11: The window-length words are writable without unlocking and read back the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting and register clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Read strobe; `rdata` is valid in the same cycle |
| addr | input | 5 | Byte address of the register word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data; 0 when `rd_en` is low or the address is unmapped |
| wdg_rst | output | 1 | Watchdog reset request, registered and sticky |

## Verification
The bench places restarts on the exact window edges: the last closed cycle, the first open cycle and the last open cycle. A design that is off by one cycle either punishes a legal restart or accepts an early one. It checks that expiry falls exactly at C+O, which catches a counter that also spends a cycle on zero. It also rewrites the lengths in mid-period, so a design that reads the live length registers at the phase change would expire late. Further cases cover a locked write, a consumed unlock, disabling and an idle restart. A design that failed to consume the unlock, or that acted on a locked write, would show a changed enable bit or a spurious reset.

// File: rtl/win_wdg_pkg.sv
package win_wdg_pkg;

    // Byte offsets of the register words
    localparam int OFF_UNLOCK = 'h00;
    localparam int OFF_CTRL   = 'h04;
    localparam int OFF_CLOSED = 'h0C;
    localparam int OFF_OPEN   = 'h10;

    // Bit positions inside the unlock and control words
    localparam int BIT_UNLOCK = 0;
    localparam int BIT_EN     = 0;
    localparam int BIT_KICK   = 8;
    localparam int BIT_FAULT  = 16;
    localparam int BIT_EARLY  = 17;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_CLOSED = 2'd1,
        PH_OPEN   = 2'd2,
        PH_FIRED  = 2'd3
    } phase_e;

endpackage

// File: rtl/wdg_regfile.sv
module wdg_regfile
    import win_wdg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              fired,
    input  logic              fire_early,
    input  logic              fire_late,
    output logic              start,
    output logic              stop,
    output logic              kick,
    output logic              unlock,
    output logic              en,
    output logic [DATA_W-1:0] closed_len,
    output logic [DATA_W-1:0] open_len
);

    localparam logic [ADDR_W-1:0] A_UNLOCK = ADDR_W'(OFF_UNLOCK);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_CLOSED = ADDR_W'(OFF_CLOSED);
    localparam logic [ADDR_W-1:0] A_OPEN   = ADDR_W'(OFF_OPEN);

    typedef struct packed {
        logic              unlock;
        logic              en;
        logic              fault;
        logic              early;
        logic [DATA_W-1:0] closed_len;
        logic [DATA_W-1:0] open_len;
    } regs_t;

    regs_t q, d;
    logic  ctrl_wr;

    always_comb begin
        d       = q;
        start   = 1'b0;
        stop    = 1'b0;
        kick    = 1'b0;
        ctrl_wr = wr_en && (addr == A_CTRL);

        if (wr_en && addr == A_UNLOCK) d.unlock = wdata[BIT_UNLOCK];
        if (wr_en && addr == A_CLOSED) d.closed_len = wdata;
        if (wr_en && addr == A_OPEN)   d.open_len = wdata;

        if (ctrl_wr) begin
            d.unlock = 1'b0;
            if (q.unlock) begin
                if (wdata[BIT_FAULT]) begin
                    d.fault = 1'b0;
                    d.early = 1'b0;
                end
                if (!fired) begin
                    d.en  = wdata[BIT_EN];
                    start = wdata[BIT_EN] && !q.en;
                    stop  = !wdata[BIT_EN] && q.en;
                    kick  = wdata[BIT_EN] && q.en && wdata[BIT_KICK];
                end
            end
        end

        // A new fault wins over a clear in the same cycle
        if (fire_early || fire_late) begin
            d.fault = 1'b1;
            d.early = fire_early;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                A_UNLOCK: rdata[BIT_UNLOCK] = q.unlock;
                A_CTRL: begin
                    rdata[BIT_EN]    = q.en;
                    rdata[BIT_FAULT] = q.fault;
                    rdata[BIT_EARLY] = q.early;
                end
                A_CLOSED: rdata = q.closed_len;
                A_OPEN:   rdata = q.open_len;
                default:  rdata = '0;
            endcase
        end
    end

    assign unlock     = q.unlock;
    assign en         = q.en;
    assign closed_len = q.closed_len;
    assign open_len   = q.open_len;

endmodule

// File: rtl/wdg_window_fsm.sv
module wdg_window_fsm
    import win_wdg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              kick,
    input  logic [DATA_W-1:0] closed_len,
    input  logic [DATA_W-1:0] open_len,
    output phase_e            phase,
    output logic              fire_early,
    output logic              fire_late,
    output logic              wdg_rst
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    typedef struct packed {
        phase_e            phase;
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] open_sh;   // open length captured at start or restart
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d          = q;
        fire_early = 1'b0;
        fire_late  = 1'b0;
        case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    d.phase   = PH_CLOSED;
                    d.cnt     = closed_len;
                    d.open_sh = open_len;
                end
            end
            PH_CLOSED: begin
                if (stop) begin
                    d.phase = PH_IDLE;
                end else if (kick) begin
                    d.phase    = PH_FIRED;
                    fire_early = 1'b1;
                end else if (q.cnt <= ONE) begin
                    d.phase = PH_OPEN;
                    d.cnt   = q.open_sh;
                end else begin
                    d.cnt = q.cnt - ONE;
                end
            end
            PH_OPEN: begin
                if (stop) begin
                    d.phase = PH_IDLE;
                end else if (kick) begin
                    d.phase   = PH_CLOSED;
                    d.cnt     = closed_len;
                    d.open_sh = open_len;
                end else if (q.cnt <= ONE) begin
                    d.phase   = PH_FIRED;
                    fire_late = 1'b1;
                end else begin
                    d.cnt = q.cnt - ONE;
                end
            end
            default: d.phase = PH_FIRED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: PH_IDLE, cnt: '0, open_sh: '0};
        else        q <= d;
    end

    assign phase   = q.phase;
    assign wdg_rst = (q.phase == PH_FIRED);

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
    import win_wdg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              wdg_rst
);

    logic              start_w, stop_w, kick_w;
    logic              unlock_w, en_w;
    logic              fire_early_w, fire_late_w;
    logic [DATA_W-1:0] closed_len_w, open_len_w;
    phase_e            phase_w;

    wdg_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .fired      (wdg_rst),
        .fire_early (fire_early_w),
        .fire_late  (fire_late_w),
        .start      (start_w),
        .stop       (stop_w),
        .kick       (kick_w),
        .unlock     (unlock_w),
        .en         (en_w),
        .closed_len (closed_len_w),
        .open_len   (open_len_w)
    );

    wdg_window_fsm #(.DATA_W(DATA_W)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_w),
        .stop       (stop_w),
        .kick       (kick_w),
        .closed_len (closed_len_w),
        .open_len   (open_len_w),
        .phase      (phase_w),
        .fire_early (fire_early_w),
        .fire_late  (fire_late_w),
        .wdg_rst    (wdg_rst)
    );

endmodule

// File: rtl/wdg_chk.sv
module wdg_chk
    import win_wdg_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              kick_bit,
    input logic              wdg_rst,
    input logic              unlock,
    input logic              en,
    input logic              kick,
    input phase_e            phase
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);

    // R6
    rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_rst |=> wdg_rst);

    // R2
    locked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTRL && !unlock) |=> $stable(en));

    // R2
    unlock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTRL) |=> !unlock);

    // R4
    early_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && phase == PH_CLOSED) |=> wdg_rst);

    // R8
    kick_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_CTRL) |-> !kick_bit);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |=> !wdg_rst);

endmodule

bind win_watchdog wdg_chk #(.ADDR_W(ADDR_W)) i_wdg_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .kick_bit (rdata[8]),
    .wdg_rst  (wdg_rst),
    .unlock   (unlock_w),
    .en       (en_w),
    .kick     (kick_w),
    .phase    (phase_w)
);

// File: tb/test_win_watchdog.sv
`timescale 1ns/1ps
module test_win_watchdog;

    localparam logic [4:0] A_UNL = 5'h00;
    localparam logic [4:0] A_CTL = 5'h04;
    localparam logic [4:0] A_CLO = 5'h0C;
    localparam logic [4:0] A_OPN = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        wdg_rst;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    win_watchdog i_win_watchdog (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .wdg_rst(wdg_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        rd_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic start(input int c, input int o);
        wr(A_CLO, c);
        wr(A_OPN, o);
        wr(A_UNL, 32'h1);
        wr(A_CTL, 32'h1);
    endtask

    task automatic kick_now();
        wr(A_UNL, 32'h1);
        wr(A_CTL, 32'h101);
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        chk("R1 wdg_rst", wdg_rst, 0);
        rd(A_UNL, v); chk("R1 unlock", v, 0);
        rd(A_CTL, v); chk("R1 ctrl", v, 0);
        rd(A_CLO, v); chk("R1 closed", v, 0);
        rd(A_OPN, v); chk("R1 open", v, 0);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        do_reset();
        wr(A_CLO, 1); wr(A_OPN, 1);
        wr(A_CTL, 32'h1);
        rd(A_CTL, v); chk("R2 locked write ignored", v, 0);
        repeat (5) @(negedge clk);
        chk("R2 no start when locked", wdg_rst, 0);
        wr(A_UNL, 32'h1);
        rd(A_UNL, v); chk("R2 unlock set", v, 1);
        wr(A_CTL, 32'h1);
        rd(A_UNL, v); chk("R2 unlock consumed", v, 0);
        rd(A_CTL, v); chk("R2 enable honoured", v, 1);
        wr(A_CTL, 32'h0);
        rd(A_CTL, v); chk("R2 second write locked", v[0], 1);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        do_reset();
        start(5, 4);
        repeat (8) @(negedge clk);
        chk("R3 low before C+O", wdg_rst, 0);
        @(negedge clk);
        chk("R3 high at C+O", wdg_rst, 1);
        rd(A_CTL, v); chk("R7 late fault status", v, 32'h0001_0001);
    endtask

    task automatic t_early();
        logic [31:0] v;
        do_reset();
        start(5, 4);
        repeat (3) @(negedge clk);
        kick_now();                         // sampled in the last closed cycle
        chk("R4 early restart fires", wdg_rst, 1);
        rd(A_CTL, v); chk("R4 early fault status", v, 32'h0003_0001);
        wr(A_UNL, 32'h1); wr(A_CTL, 32'h0001_0001);
        rd(A_CTL, v); chk("R7 fault cleared", v, 32'h0000_0001);
        chk("R6 reset held after clear", wdg_rst, 1);
        wr(A_UNL, 32'h1); wr(A_CTL, 32'h0);
        repeat (3) @(negedge clk);
        chk("R6 reset held after disable", wdg_rst, 1);
        do_reset();
        chk("R6 released by rst_n", wdg_rst, 0);
    endtask

    task automatic t_legal_kick();
        logic [31:0] v;
        do_reset();
        start(5, 4);
        repeat (4) @(negedge clk);
        kick_now();                         // first open cycle, t=6
        chk("R5 first open restart", wdg_rst, 0);
        rd(A_CTL, v); chk("R8 restart bit reads 0", v, 32'h1);
        repeat (7) @(negedge clk);
        kick_now();                         // last open cycle, t=15
        chk("R5 last open restart", wdg_rst, 0);
        repeat (8) @(negedge clk);
        chk("R5 low before new expiry", wdg_rst, 0);
        @(negedge clk);
        chk("R5 expiry C+O after restart", wdg_rst, 1);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        do_reset();
        start(5, 4);
        repeat (3) @(negedge clk);
        wr(A_UNL, 32'h1); wr(A_CTL, 32'h0);
        repeat (12) @(negedge clk);
        chk("R9 disabled no reset", wdg_rst, 0);
        rd(A_CTL, v); chk("R9 enable cleared", v, 0);
        wr(A_UNL, 32'h1); wr(A_CTL, 32'h100);
        repeat (20) @(negedge clk);
        chk("R9 idle restart ignored", wdg_rst, 0);
        rd(A_CTL, v); chk("R9 still idle", v, 0);
    endtask

    task automatic t_live_update();
        logic [31:0] v;
        do_reset();
        start(5, 4);
        wr(A_CLO, 50);
        wr(A_OPN, 50);
        rd(A_CLO, v); chk("R11 closed readback", v, 50);
        rd(A_OPN, v); chk("R11 open readback", v, 50);
        repeat (6) @(negedge clk);
        chk("R10 old period low", wdg_rst, 0);
        @(negedge clk);
        chk("R10 old period expiry", wdg_rst, 1);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_lock();
        t_timeout();
        t_early();
        t_legal_kick();
        t_disable();
        t_live_update();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule